// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits beside an I2C controller core and turns its seven event strobes into software-visible interrupt state. Each strobe sets a sticky flag in a status register. A mask register enables or disables each source for the interrupt line. A vector register returns a small code for the most urgent event that is both pending and enabled.

Reading the vector register also consumes the event it reports. Software can therefore service the controller with a plain loop: read the vector, handle the code, and stop when the code is 0. Flags can also be cleared directly by writing ones to the status register. Two level inputs from the core, bus busy and receive shift full, are shown in the status register for information only.

The register port is a simple single-cycle interface. Read data is combinational from the address. A write, or the side effect of a vector read, takes effect at the next rising clock edge.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset the mask register reads 0, every status bit held in the block reads 0, `irq_o` is low and a vector read returns 0.
- R2: A pulse on `evt_set_i[k]` latches a sticky flag at status bit k. The event order is k=0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. The flag is visible from the edge that samples the pulse.
- R3: A write to the status register (address 1) clears each event flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R4: The mask register (address 0) holds bit k as the enable for event k, which is the same bit order as the status register. Bits 15..7 read as 0.
- R5: `irq_o` is high exactly when some event flag is set and its mask bit is 1.
- R6: A read of the vector register (address 2) returns k+1 for the lowest k whose flag and mask bit are both set, giving codes 1 to 7.
- R7: A vector read that returns a nonzero code clears that one flag at the next edge and leaves all other flags as they were.
- R8: When no enabled flag is pending, the vector reads 0 and the read changes no state.
- R9: Status bit 11 follows `rx_shift_full_i` and status bit 12 follows `bus_busy_i`. Neither bit affects the vector or `irq_o`, and status writes do not change them.
- R10: If a set pulse for a flag coincides with a clear of that flag, whether by status write or by vector read, the flag remains set.
- R11: With the mask at 0, `irq_o` stays low and the vector reads 0, while the status register still reports the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 7 | Event set strobes from the controller core |
| bus_busy_i | input | 1 | Bus busy level (status only) |
| rx_shift_full_i | input | 1 | Receive shift register full level (status only) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (vector consume) |
| addr_i | input | 2 | Register select: 0 mask, 1 status, 2 vector |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request line |

## Verification
On every cycle, the assertions check the following:
- A set strobe always leaves its flag set, even when a clear arrives in the same cycle.
- A clear with no coinciding set empties the flag.
- The encoder grants at most one pending source, and no lower-numbered pending source is skipped.
- A zero mask keeps the line low.
- A vector read taken while the line is low returns 0.

The bench scenarios cover what the assertions cannot. They sweep all 128 flag patterns against several masks and drain each pattern through repeated vector reads, checking the full code sequence and the masked flags left behind. They also check the placement of the status-only bits and that status writes do not affect them.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NUM_EVT = 7;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_STAT = 2'd1,
    REG_VEC  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_EVT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] flag_o
);
  logic [N_EVT-1:0] flag_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;   // set beats clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_EVT  = 7,
  localparam int unsigned CODE_W = $clog2(N_EVT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  req_i,
  output logic [N_EVT-1:0]  grant_o,
  output logic [CODE_W-1:0] code_o
);
  logic found;

  // lowest index wins; code is index + 1, zero when idle
  always_comb begin
    grant_o = '0;
    code_o  = '0;
    found   = 1'b0;
    for (int i = 0; i < N_EVT; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        code_o     = CODE_W'(i + 1);
        found      = 1'b1;
      end
    end
  end

  p_one_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  p_lowest_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> ((req_i & (grant_o - 1'b1)) == '0));
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_EVT   = 7,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RSF_POS = 11,
  parameter int unsigned BB_POS  = 12,
  localparam int unsigned CODE_W = $clog2(N_EVT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_EVT-1:0]  flag_i,
  input  logic [N_EVT-1:0]  grant_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bus_busy_i,
  input  logic              rx_shift_full_i,
  output logic [N_EVT-1:0]  mask_o,
  output logic [N_EVT-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e         sel;
  logic [N_EVT-1:0] mask_q;
  logic [DATA_W-1:0] stat_word;
  logic             unused_wbits;

  assign sel          = reg_sel_e'(addr_i);
  assign unused_wbits = ^wdata_i[DATA_W-1:N_EVT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (wr_en_i && sel == REG_MASK)  mask_q <= wdata_i[N_EVT-1:0];
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && sel == REG_STAT) clr_o = clr_o | wdata_i[N_EVT-1:0];
    if (rd_en_i && sel == REG_VEC)  clr_o = clr_o | grant_i;
  end

  always_comb begin
    stat_word                  = '0;
    stat_word[N_EVT-1:0]       = flag_i;
    stat_word[RSF_POS]         = rx_shift_full_i;
    stat_word[BB_POS]          = bus_busy_i;
  end

  always_comb begin
    unique case (sel)
      REG_MASK: rdata_o = DATA_W'(mask_q);
      REG_STAT: rdata_o = stat_word;
      REG_VEC:  rdata_o = DATA_W'(code_i);
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_EVT   = NUM_EVT,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RSF_POS = 11,
  parameter int unsigned BB_POS  = 12,
  localparam int unsigned CODE_W = $clog2(N_EVT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_set_i,
  input  logic              bus_busy_i,
  input  logic              rx_shift_full_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_EVT-1:0]  flag, mask, clr, grant, pend;
  logic [CODE_W-1:0] code;

  irq_flag_bank #(.N_EVT(N_EVT)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  assign pend = flag & mask;

  irq_prio_enc #(.N_EVT(N_EVT)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (pend),
    .grant_o (grant),
    .code_o  (code)
  );

  irq_reg_if #(
    .N_EVT(N_EVT), .DATA_W(DATA_W), .RSF_POS(RSF_POS), .BB_POS(BB_POS)
  ) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en_i),
    .rd_en_i         (rd_en_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .flag_i          (flag),
    .grant_i         (grant),
    .code_i          (code),
    .bus_busy_i      (bus_busy_i),
    .rx_shift_full_i (rx_shift_full_i),
    .mask_o          (mask),
    .clr_o           (clr),
    .rdata_o         (rdata_o)
  );

  assign irq_o = |pend;

  p_mask_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  p_idle_vec_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2 && !irq_o) |-> (rdata_o == '0));
endmodule

// File: tb/i2c_irq_vec_test.sv
`timescale 1ns/1ps
module i2c_irq_vec_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  evt_set = '0;
  logic        bb = 1'b0, rsf = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  i2c_irq_vec uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_set_i(evt_set), .bus_busy_i(bb),
    .rx_shift_full_i(rsf), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  // combinational peek, no side effect
  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata;
    step();
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_set = e;
    step();
    evt_set = '0;
  endtask

  function automatic logic [15:0] low_code(input logic [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] masks [5];
    masks[0] = 7'h7F; masks[1] = 7'h00; masks[2] = 7'h55; masks[3] = 7'h2A; masks[4] = 7'h41;
    #12; rst_ni = 1'b1; step();

    // R1 reset state
    peek(2'd0, v); chk("R1 mask", v, 16'h0);
    peek(2'd1, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rd(2'd2, v);   chk("R1 vector", v, 16'h0);

    // R4 mask width
    wr(2'd0, 16'hFFFF); peek(2'd0, v); chk("R4 mask readback", v, 16'h007F);
    wr(2'd0, 16'h0000);

    // R9 status-only bits
    bb = 1'b1; rsf = 1'b0; step(); peek(2'd1, v); chk("R9 busy bit12", v, 16'h1000);
    bb = 1'b0; rsf = 1'b1; step(); peek(2'd1, v); chk("R9 rsfull bit11", v, 16'h0800);
    wr(2'd0, 16'h007F);
    bb = 1'b1; wr(2'd1, 16'h1800);
    peek(2'd1, v); chk("R9 write ignored", v, 16'h1800);
    chk("R9 no irq", 16'(irq), 16'h0);
    rd(2'd2, v); chk("R9 no vector", v, 16'h0);
    bb = 1'b0; rsf = 1'b0;

    // R3 partial W1C
    pulse(7'h3C); wr(2'd1, 16'h0014);
    peek(2'd1, v); chk("R3 partial clear", v, 16'h0028);
    wr(2'd1, 16'h007F);

    // R10 set wins over status write
    pulse(7'h04);
    evt_set = 7'h04; wr(2'd1, 16'h0004); evt_set = '0;
    peek(2'd1, v); chk("R10 set vs w1c", v, 16'h0004);
    wr(2'd1, 16'h007F);

    // R10 set wins over vector read
    pulse(7'h01);
    evt_set = 7'h01; rd(2'd2, v); evt_set = '0;
    chk("R10 vector code", v, 16'h1);
    peek(2'd1, v); chk("R10 set vs vector read", v, 16'h0001);
    wr(2'd1, 16'h007F);

    // R8 empty read has no effect on masked flags
    wr(2'd0, 16'h0000); pulse(7'h12);
    rd(2'd2, v); chk("R8 zero vector", v, 16'h0);
    peek(2'd1, v); chk("R8 state kept", v, 16'h0012);
    wr(2'd1, 16'h007F);

    // exhaustive sweep: R2 R5 R6 R7 R11
    for (int mi = 0; mi < 5; mi++) begin
      for (int p = 0; p < 128; p++) begin
        logic [6:0] m, rem;
        m = masks[mi];
        wr(2'd0, 16'(m));
        pulse(7'(p));
        peek(2'd1, v); chk("R2 latched flags", v, 16'(p));
        chk(m == 0 ? "R11 irq off" : "R5 irq", 16'(irq), 16'(|(7'(p) & m)));
        rem = 7'(p) & m;
        for (int k = 0; k < 8; k++) begin
          rd(2'd2, v);
          chk(m == 0 ? "R11 vector zero" : "R6 vector code", v, low_code(rem));
          if (low_code(rem) == 0) break;
          rem[low_code(rem) - 1] = 1'b0;
        end
        peek(2'd1, v); chk("R7 only consumed cleared", v, 16'(7'(p) & ~m));
        chk("R5 irq after drain", 16'(irq), 16'h0);
        wr(2'd1, 16'h007F);
        peek(2'd1, v); chk("R3 clear all", v, 16'h0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule